// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block is the front end for four external interrupt pins. Each pin is first passed through a two-flop synchroniser. The block then turns the pin into a request according to a per-channel sense mode: low level, high level, rising edge or falling edge. Requests from the edge modes are held in sticky pending flags until software clears them. Requests from the level modes follow the synchronised pin directly and are never latched. The requests are masked per channel, and the surviving ones are ORed into a single interrupt line, which feeds a separate prioritising controller.

Software reaches the block through a simple word-addressed register bus. The bus has a select, a write strobe, an 8-bit byte offset and 32-bit data. Reads are combinational.

There are three registers:
- The sense-select register at offset 0x08. It holds one 2-bit field per channel.
- The enable register at offset 0x0C. It holds one bit per channel in bits 3:0.
- The pending register at offset 0x10. Reading it returns the pending flags in bits 3:0. Writing a 1 to a bit clears that flag.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, the sense-select register reads 0x00000055 (every channel is in high-level mode). The enable register reads 0, the pending register reads 0, and `irq_o` is 0.
- R2: Channel n's sense field sits in bits [2n+1:2n] at offset 0x08, and all eight bits are read/write. Bits 31:8 ignore writes and read as 0. The enable register keeps only bits 3:0 and reads 0 above them.
- R3: Sense code 00 (low level): the channel requests while its synchronised pin is 0. The request changes on the second rising clock edge after the pin changes, and it drops as soon as the pin returns high. The pending flag stays 0.
- R4: Sense code 01 (high level): the channel requests while its synchronised pin is 1. It has the same two-edge latency as R3 and sets no pending flag.
- R5: Sense code 10 (rising edge): a 0-to-1 pin transition sets the channel's pending bit on the third rising clock edge after the pin change. The bit stays set after the pin falls again.
- R6: Sense code 11 (falling edge): a 1-to-0 pin transition sets the pending bit with the same timing as R5. The bit is sticky in the same way.
- R7: Writing to offset 0x10 clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged. A new edge in the same cycle as the clear wins over the clear.
- R8: A sense-select write that changes a channel's field clears that channel's pending bit at the same clock edge. This holds even if an edge is detected in that cycle.
- R9: `irq_o` is the OR over all channels of (request AND enable bit). With enable 0 on a channel, that channel never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 4 | Asynchronous external interrupt pins |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe (1 = write) |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational) |
| irq_o | output | 1 | Combined masked interrupt request |

## Verification
The ports expose the internal state in these ways:
- A wrong sense field shows immediately, either on a read of offset 0x08 or as a request of the wrong polarity two edges after the next pin change.
- A lost or stuck pending flag shows on the pending read, and on `irq_o`, one edge after the edge that should have set or cleared it.
- A synchroniser with the wrong depth shifts every request by a whole cycle, so it is caught by sampling at exactly the second and third edges after a pin change.
- An enable bit decoded wrongly shows on `irq_o` within the same cycle as the enable write.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_FALL = 2'b11
  } sense_e;

  localparam int unsigned BUS_AW = 8;
  localparam int unsigned BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_SENSE  = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_ENABLE = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_PEND   = 8'h10;

  localparam logic [1:0] SENSE_RESET = 2'b01;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb begin
    stage_d[0] = pin_i;
    for (int k = 1; k < STAGES; k++) begin
      stage_d[k] = stage_q[k-1];
    end
    prev_d = stage_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) begin
        stage_q[k] <= '0;
      end
      prev_q <= '0;
    end else begin
      for (int k = 0; k < STAGES; k++) begin
        stage_q[k] <= stage_d[k];
      end
      prev_q <= prev_d;
    end
  end

  assign lvl_o  = stage_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       lvl_i,
  input  logic       prev_i,
  input  logic       clr_i,
  input  logic       flush_i,
  output logic       pend_o,
  output logic       req_o
);

  sense_e mode;
  logic   edge_hit;
  logic   pend_q;
  logic   pend_d;
  logic   pend_en;

  assign mode = sense_e'(mode_i);

  always_comb begin
    unique case (mode)
      SENSE_RISE: edge_hit =  lvl_i & ~prev_i;
      SENSE_FALL: edge_hit = ~lvl_i &  prev_i;
      default:    edge_hit = 1'b0;
    endcase
  end

  always_comb begin
    pend_en = flush_i | edge_hit | clr_i;
    if (flush_i) begin
      pend_d = 1'b0;
    end else if (edge_hit) begin
      pend_d = 1'b1;
    end else begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  always_comb begin
    unique case (mode)
      SENSE_LOW:  req_o = ~lvl_i;
      SENSE_HIGH: req_o =  lvl_i;
      default:    req_o =  pend_q;
    endcase
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel_i,
  input  logic                bus_we_i,
  input  logic [BUS_AW-1:0]   bus_addr_i,
  input  logic [BUS_DW-1:0]   bus_wdata_i,
  output logic [BUS_DW-1:0]   bus_rdata_o,
  input  logic [NUM_CH-1:0]   pend_i,
  output logic [2*NUM_CH-1:0] sense_o,
  output logic [NUM_CH-1:0]   en_o,
  output logic [NUM_CH-1:0]   clr_o,
  output logic [NUM_CH-1:0]   flush_o
);

  localparam int unsigned SW = 2 * NUM_CH;

  logic [SW-1:0]     sense_q;
  logic [SW-1:0]     sense_d;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] en_d;
  logic              wr_sense;
  logic              wr_en;
  logic              wr_pend;

  assign wr_sense = bus_sel_i & bus_we_i & (bus_addr_i == OFS_SENSE);
  assign wr_en    = bus_sel_i & bus_we_i & (bus_addr_i == OFS_ENABLE);
  assign wr_pend  = bus_sel_i & bus_we_i & (bus_addr_i == OFS_PEND);

  assign sense_d = bus_wdata_i[SW-1:0];
  assign en_d    = bus_wdata_i[NUM_CH-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= {NUM_CH{SENSE_RESET}};
    end else if (wr_sense) begin
      sense_q <= sense_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q <= en_d;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ctl
    assign flush_o[c] = wr_sense & (sense_d[2*c +: 2] != sense_q[2*c +: 2]);
    assign clr_o[c]   = wr_pend & bus_wdata_i[c];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_sel_i && !bus_we_i) begin
      unique case (bus_addr_i)
        OFS_SENSE:  bus_rdata_o[SW-1:0]     = sense_q;
        OFS_ENABLE: bus_rdata_o[NUM_CH-1:0] = en_q;
        OFS_PEND:   bus_rdata_o[NUM_CH-1:0] = pend_i;
        default:    bus_rdata_o = '0;
      endcase
    end
  end

  assign sense_o = sense_q;
  assign en_o    = en_q;

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   irq_pin_i,
  input  logic                bus_sel_i,
  input  logic                bus_we_i,
  input  logic [BUS_AW-1:0]   bus_addr_i,
  input  logic [BUS_DW-1:0]   bus_wdata_i,
  output logic [BUS_DW-1:0]   bus_rdata_o,
  output logic                irq_o
);

  logic [2*NUM_CH-1:0] sense_q;
  logic [NUM_CH-1:0]   en_q;
  logic [NUM_CH-1:0]   clr;
  logic [NUM_CH-1:0]   flush;
  logic [NUM_CH-1:0]   pend;
  logic [NUM_CH-1:0]   req;
  logic [NUM_CH-1:0]   sync_lvl;
  logic [NUM_CH-1:0]   sync_prev;

  ext_irq_sync #(
    .WIDTH  (NUM_CH),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (irq_pin_i),
    .lvl_o  (sync_lvl),
    .prev_o (sync_prev)
  );

  ext_irq_regs #(
    .NUM_CH (NUM_CH)
  ) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .pend_i      (pend),
    .sense_o     (sense_q),
    .en_o        (en_q),
    .clr_o       (clr),
    .flush_o     (flush)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ext_irq_chan i_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode_i  (sense_q[2*c +: 2]),
      .lvl_i   (sync_lvl[c]),
      .prev_i  (sync_prev[c]),
      .clr_i   (clr[c]),
      .flush_i (flush[c]),
      .pend_o  (pend[c]),
      .req_o   (req[c])
    );
  end

  assign irq_o = |(req & en_q);

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                irq_o,
  input logic [NUM_CH-1:0]   en_q,
  input logic [2*NUM_CH-1:0] sense_q,
  input logic [NUM_CH-1:0]   pend,
  input logic [NUM_CH-1:0]   sync_lvl,
  input logic [NUM_CH-1:0]   sync_prev,
  input logic [NUM_CH-1:0]   clr,
  input logic [NUM_CH-1:0]   flush
);

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|en_q));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[c] && !flush[c] && !clr[c]) |=> pend[c]);

    // R3
    level_no_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sense_q[2*c+1]) |-> !pend[c]);

    // R5
    rise_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_q[2*c +: 2] == 2'b10 && sync_lvl[c] && !sync_prev[c] && !flush[c]) |=> pend[c]);

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush[c] |=> !pend[c]);
  end

endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .en_q      (en_q),
  .sense_q   (sense_q),
  .pend      (pend),
  .sync_lvl  (sync_lvl),
  .sync_prev (sync_prev),
  .clr       (clr),
  .flush     (flush)
);

// File: tb/test_ext_irq_sense.sv
`timescale 1ns/1ps
module test_ext_irq_sense;

  logic        clk;
  logic        rst_n;
  logic [3:0]  pins;
  logic        sel;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  ext_irq_sense i_ext_irq_sense (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pin_i   (pins),
    .bus_sel_i   (sel),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #0.5;
    d = rdata;
    sel = 1'b0;
    #0.1;
  endtask

  function automatic logic [31:0] with_field(input int c, input logic [1:0] m);
    logic [31:0] v;
    v = 32'h55;
    v[2*c +: 2] = m;
    return v;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; pins = '0; sel = 0; we = 0; addr = '0; wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // R1 reset state
    rd(8'h08, d); check("R1 sense reset", d, 32'h55);
    rd(8'h0C, d); check("R1 enable reset", d, 32'h0);
    rd(8'h10, d); check("R1 pending reset", d, 32'h0);
    check("R1 irq reset", {31'b0, irq}, 32'h0);

    // R2 register sweep, upper bits ignored
    for (int v = 0; v < 256; v++) begin
      wr(8'h08, {24'hA5C3F0, v[7:0]});
      rd(8'h08, d);
      check("R2 sense readback", d, {24'h0, v[7:0]});
    end
    wr(8'h08, 32'h55);
    wr(8'h0C, 32'hFFFF_FFF5);
    rd(8'h0C, d); check("R2 enable width", d, 32'h5);
    wr(8'h0C, 32'h0);

    // R3 / R4 level modes, latency two edges
    for (int c = 0; c < 4; c++) begin
      for (int m = 0; m < 2; m++) begin
        pins = '0;
        wr(8'h08, with_field(c, m[1:0]));
        wr(8'h0C, 32'h1 << c);
        tick(3);
        check(m == 0 ? "R3 low idle" : "R4 high idle", {31'b0, irq}, {31'b0, m == 0});
        pins[c] = 1'b1;
        tick(1);
        check(m == 0 ? "R3 one edge" : "R4 one edge", {31'b0, irq}, {31'b0, m == 0});
        tick(1);
        check(m == 0 ? "R3 two edges" : "R4 two edges", {31'b0, irq}, {31'b0, m == 1});
        rd(8'h10, d);
        check(m == 0 ? "R3 no pend" : "R4 no pend", d, 32'h0);
        pins[c] = 1'b0;
        tick(2);
        check(m == 0 ? "R3 follows pin" : "R4 follows pin", {31'b0, irq}, {31'b0, m == 0});
      end
    end
    pins = '0;
    wr(8'h08, 32'h55);
    tick(3);

    // R5 / R6 edge modes, W1C (R7), mode change flush (R8)
    for (int c = 0; c < 4; c++) begin
      for (int m = 2; m < 4; m++) begin
        logic idle;
        idle = (m == 3);
        pins[c] = idle;
        tick(3);
        wr(8'h08, with_field(c, m[1:0]));
        wr(8'h0C, 32'h1 << c);
        tick(3);
        wr(8'h10, 32'hF);
        rd(8'h10, d); check("R7 cleared start", d, 32'h0);
        check("R9 idle irq", {31'b0, irq}, 32'h0);
        pins[c] = ~idle;
        tick(2);
        rd(8'h10, d); check(m == 2 ? "R5 not yet" : "R6 not yet", d, 32'h0);
        tick(1);
        rd(8'h10, d); check(m == 2 ? "R5 set" : "R6 set", d, 32'h1 << c);
        check(m == 2 ? "R5 irq" : "R6 irq", {31'b0, irq}, 32'h1);
        pins[c] = idle;
        tick(4);
        rd(8'h10, d); check(m == 2 ? "R5 sticky" : "R6 sticky", d, 32'h1 << c);
        wr(8'h10, ~(32'h1 << c) & 32'hF);
        rd(8'h10, d); check("R7 zero bit keeps", d, 32'h1 << c);
        wr(8'h10, 32'h1 << c);
        rd(8'h10, d); check("R7 one bit clears", d, 32'h0);
        check("R7 irq drops", {31'b0, irq}, 32'h0);
        pins[c] = ~idle;
        tick(3);
        rd(8'h10, d); check("R8 pend before change", d, 32'h1 << c);
        wr(8'h08, with_field(c, (m == 2) ? 2'b11 : 2'b10));
        rd(8'h10, d); check("R8 change clears", d, 32'h0);
        wr(8'h08, 32'h55);
        pins[c] = 1'b0;
        tick(4);
      end
    end

    // R7 clear of one of two pending channels
    pins = '0;
    wr(8'h08, 32'h5A);
    tick(3);
    pins = 4'b0011;
    tick(3);
    rd(8'h10, d); check("R7 two pending", d, 32'h3);
    wr(8'h10, 32'h1);
    rd(8'h10, d); check("R7 other kept", d, 32'h2);
    wr(8'h08, 32'h55);
    pins = '0;
    tick(3);

    // R9 mask sweep in high-level mode
    for (int p = 0; p < 16; p++) begin
      for (int e = 0; e < 16; e++) begin
        pins = p[3:0];
        wr(8'h0C, e);
        tick(2);
        check("R9 mask", {31'b0, irq}, {31'b0, |(p[3:0] & e[3:0])});
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule